// File: doc/BRIEF.md
# I2C master START generator with stuck-data recovery

This block produces the START condition for an I2C master. Software raises a start request; once the bus is free, the block pulls SDA low while SCL stays high, reports status 08h and raises its interrupt flag. A forced-access timeout pulse lets a pending request take a bus that is still marked busy. After a START has been sent the block holds the bus with SCL low. A repeated-START request then releases SDA and SCL and sends a new START, which reports status 10h.

If a slave has lost bit synchronisation and holds SDA low, a START cannot be made. The block then clocks SCL by itself. After each group of extra pulses (two by default) it checks SDA again and retries the START, with no software action between retries. When SDA comes back high, a normal START follows. If SCL itself is held low by another device, the block only waits and never drives a clock. Both lines are modelled as open-drain pull-down enables, and the wired bus levels are read back through a two-flop synchroniser.

Top module: `i2c_start_gen`

## Requirements
- R1: When a START is due and the synchronised SDA is low while SCL is high, the block drives SCL pulses, with SDA released, instead of a START.
- R2: Extra SCL pulses come in groups of RETRY_PULSES (default 2). After each group the block checks SDA again, so the number of SCL rising edges the recovery produces before a first START is a multiple of the group size.
- R3: Once SDA is seen high, the block pulls SDA low while SCL is released for HALF_CYC clocks. It then pulls SCL low, loads status 08h for a first START and sets irq.
- R4: While bus_free is low, a pending request does nothing: no line is driven and irq stays 0. A force_tmo pulse starts the same START sequence, including recovery from a stuck SDA.
- R5: A req_rep pulse while the bus is held after a START releases SDA, then SCL, and runs the same check-and-recover sequence. A successful repeated START loads status 10h.
- R6: While the synchronised SCL is low, the block never starts driving SCL and waits. The wait timer restarts each time SCL goes low.
- R7: Each recovery pulse holds SCL low for exactly HALF_CYC clocks. The high phase lasts HALF_CYC clocks counted once the synchronised SCL is high.
- R8: start_pending rises on an accepted request and stays high until the START has been sent. It falls in the same cycle that irq rises. An accepted request clears irq.
- R9: After reset, no line is driven, status is F8h, irq is 0 and start_pending is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle pulse from software asking for a START; accepted when idle |
| req_rep | input | 1 | One-cycle pulse asking for a repeated START; accepted while holding the bus |
| force_tmo | input | 1 | One-cycle pulse meaning the bus-busy timeout expired |
| bus_free | input | 1 | High when the bus is considered free |
| sda_in | input | 1 | Wired SDA level |
| scl_in | input | 1 | Wired SCL level |
| sda_pd | output | 1 | Pull SDA low when 1 |
| scl_pd | output | 1 | Pull SCL low when 1 |
| status | output | 8 | Status code: F8h after reset, 08h after a START, 10h after a repeated START |
| irq | output | 1 | Interrupt flag, set when a START has been sent |
| start_pending | output | 1 | Request flag, held until the START is sent |

## Verification
The bench builds the block with HALF_CYC = 4 and RETRY_PULSES = 2. With these values a recovery pulse lasts only a few clocks, so slaves that hold SDA for one, two or three SCL edges can be run through to the final START in a short time. The small group size makes the rounding of the pulse count to a whole group visible: one held edge gives two rising edges and three held edges give four. The short half period also lets the bench measure the exact SCL low time and hold SCL low from outside long enough to show that the block waits.

// File: rtl/i2c_sta_pkg.sv
package i2c_sta_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PLS_LO,
        ST_PLS_HI,
        ST_STA_HOLD,
        ST_OWN,
        ST_REL_SDA
    } sta_state_e;

    localparam logic [7:0] CODE_RESET  = 8'hF8;
    localparam logic [7:0] CODE_START  = 8'h08;
    localparam logic [7:0] CODE_RSTART = 8'h10;

    typedef struct packed {
        logic sda;
        logic scl;
    } line_pair_t;

    // pull-down enables for each state
    function automatic line_pair_t drive_for(sta_state_e s);
        line_pair_t d;
        d = '{sda: 1'b0, scl: 1'b0};
        case (s)
            ST_PLS_LO:   d = '{sda: 1'b0, scl: 1'b1};
            ST_STA_HOLD: d = '{sda: 1'b1, scl: 1'b0};
            ST_OWN:      d = '{sda: 1'b1, scl: 1'b1};
            ST_REL_SDA:  d = '{sda: 1'b0, scl: 1'b1};
            default:     d = '{sda: 1'b0, scl: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic [7:0] code_for(logic rep);
        return rep ? CODE_RSTART : CODE_START;
    endfunction

endpackage

// File: rtl/i2c_sta_sync.sv
module i2c_sta_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= '1;
        else     st[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[i] <= '1;
            else     st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/i2c_sta_timer.sv
module i2c_sta_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)              cnt <= '0;
        else if (en && cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign done = en && (cnt == LAST);
endmodule

// File: rtl/i2c_sta_fsm.sv
module i2c_sta_fsm
    import i2c_sta_pkg::*;
#(
    parameter int RETRY_PULSES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_start,
    input  logic       req_rep,
    input  logic       force_tmo,
    input  logic       bus_free,
    input  logic       sda_s,
    input  logic       scl_s,
    input  logic       tmr_done,
    output sta_state_e state,
    output logic       tmr_clr,
    output logic       tmr_en,
    output logic [7:0] status,
    output logic       irq,
    output logic       pending
);
    localparam int PCW = (RETRY_PULSES > 1) ? $clog2(RETRY_PULSES) : 1;
    localparam logic [PCW-1:0] PLAST = PCW'(RETRY_PULSES - 1);

    sta_state_e nxt;
    logic [PCW-1:0] pcnt;
    logic rep;
    logic accept;
    logic sent;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:     if (pending && (bus_free || force_tmo)) nxt = ST_SETTLE;
            ST_SETTLE:   if (tmr_done) nxt = sda_s ? ST_STA_HOLD : ST_PLS_LO;
            ST_PLS_LO:   if (tmr_done) nxt = ST_PLS_HI;
            ST_PLS_HI:   if (tmr_done) nxt = (pcnt == PLAST) ? ST_SETTLE : ST_PLS_LO;
            ST_STA_HOLD: if (tmr_done) nxt = ST_OWN;
            ST_OWN:      if (pending) nxt = ST_REL_SDA;
            ST_REL_SDA:  if (tmr_done) nxt = ST_SETTLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // the settle window restarts while the clock line is held low
    assign tmr_clr = (nxt != state) || (state == ST_SETTLE && !scl_s);
    assign tmr_en  = (state == ST_SETTLE || state == ST_PLS_HI) ? scl_s : 1'b1;
    assign accept  = (state == ST_IDLE && req_start) || (state == ST_OWN && req_rep);
    assign sent    = (state == ST_STA_HOLD) && tmr_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pcnt    <= '0;
            rep     <= 1'b0;
            pending <= 1'b0;
            irq     <= 1'b0;
            status  <= CODE_RESET;
        end else begin
            state <= nxt;
            if (accept) begin
                pending <= 1'b1;
                irq     <= 1'b0;
                rep     <= (state == ST_OWN);
            end
            if (state == ST_PLS_HI && tmr_done)
                pcnt <= (pcnt == PLAST) ? '0 : pcnt + 1'b1;
            if (sent) begin
                pending <= 1'b0;
                irq     <= 1'b1;
                status  <= code_for(rep);
                pcnt    <= '0;
            end
        end
    end
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2c_sta_pkg::*;
#(
    parameter int HALF_CYC     = 8,
    parameter int RETRY_PULSES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_start,
    input  logic       req_rep,
    input  logic       force_tmo,
    input  logic       bus_free,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic       sda_pd,
    output logic       scl_pd,
    output logic [7:0] status,
    output logic       irq,
    output logic       start_pending
);
    line_pair_t raw, syn, drv;
    logic sda_syn, scl_syn;
    logic tmr_clr, tmr_en, tmr_done;
    sta_state_e state;

    assign raw = '{sda: sda_in, scl: scl_in};

    i2c_sta_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );
    assign sda_syn = syn.sda;
    assign scl_syn = syn.scl;

    i2c_sta_timer #(.LIMIT(HALF_CYC)) u_timer (
        .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en), .done(tmr_done)
    );

    i2c_sta_fsm #(.RETRY_PULSES(RETRY_PULSES)) u_fsm (
        .clk(clk), .rst(rst),
        .req_start(req_start), .req_rep(req_rep),
        .force_tmo(force_tmo), .bus_free(bus_free),
        .sda_s(sda_syn), .scl_s(scl_syn), .tmr_done(tmr_done),
        .state(state), .tmr_clr(tmr_clr), .tmr_en(tmr_en),
        .status(status), .irq(irq), .pending(start_pending)
    );

    assign drv    = drive_for(state);
    assign sda_pd = drv.sda;
    assign scl_pd = drv.scl;
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_s,
    input logic       sda_pd,
    input logic       scl_pd,
    input logic       irq,
    input logic [7:0] status,
    input logic       start_pending
);
    // R6: a clock is only started from a line seen high
    p_clock_only_when_high_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pd) |-> $past(scl_s));

    // R1: recovery pulses leave SDA released
    p_sda_free_while_clocking_r1: assert property (@(posedge clk) disable iff (rst)
        ($rose(scl_pd) && !$past(sda_pd)) |-> !sda_pd);

    // R3: START was SDA low with SCL released
    p_start_shape_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(sda_pd) && !$past(scl_pd)));

    // R5: only the two success codes come with the flag
    p_status_code_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (status == 8'h08 || status == 8'h10));

    // R8: the request flag drops only with a sent START
    p_pending_until_sent_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(start_pending) |-> $rose(irq));
endmodule

bind i2c_start_gen i2c_start_gen_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_syn), .sda_pd(sda_pd), .scl_pd(scl_pd),
    .irq(irq), .status(status), .start_pending(start_pending)
);

// File: tb/i2c_start_gen_bench.sv
module i2c_start_gen_bench;
    localparam int HALF  = 4;
    localparam int RETRY = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_start = 1'b0, req_rep = 1'b0, force_tmo = 1'b0, bus_free = 1'b1;
    logic sda_pd, scl_pd, irq, start_pending;
    logic [7:0] status;
    logic sda_bus, scl_bus, slave_low;
    logic ext_scl_low = 1'b0;

    int hold_m = 0;
    logic rc_clr = 1'b0;
    int rc = 0, lowrun = 0, last_low = 0;
    logic scl_q = 1'b1, sda_q = 1'b1, start_seen = 1'b0, scl_drove = 1'b0;
    logic irq_prev = 1'b0;

    int checks = 0, fails = 0;

    typedef struct {
        logic [7:0] st;
        int         rises;
        bit         chk_low;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    assign slave_low = (rc < hold_m);
    assign sda_bus = !sda_pd && !slave_low;
    assign scl_bus = !scl_pd && !ext_scl_low;

    i2c_start_gen #(.HALF_CYC(HALF), .RETRY_PULSES(RETRY)) u_i2c_start_gen (
        .clk(clk), .rst(rst), .req_start(req_start), .req_rep(req_rep),
        .force_tmo(force_tmo), .bus_free(bus_free),
        .sda_in(sda_bus), .scl_in(scl_bus),
        .sda_pd(sda_pd), .scl_pd(scl_pd), .status(status), .irq(irq),
        .start_pending(start_pending)
    );

    // bus observer and slave model
    always @(posedge clk) begin
        scl_q <= scl_bus;
        sda_q <= sda_bus;
        if (rc_clr) begin
            rc <= 0;
            start_seen <= 1'b0;
            scl_drove <= 1'b0;
        end else begin
            if (scl_bus && !scl_q) rc <= rc + 1;
            if (!sda_bus && sda_q && scl_bus && sda_pd) start_seen <= 1'b1;
            if (scl_pd) scl_drove <= 1'b1;
        end
        if (!scl_bus) lowrun <= lowrun + 1;
        else begin
            if (!scl_q) last_low <= lowrun;
            lowrun <= 0;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop an expected item on each rising irq
    always @(negedge clk) begin
        if (!rst && irq && !irq_prev) begin
            if (sb.size() == 0) chk("R3 unexpected irq", 1, 0);
            else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " status"}, int'(status), int'(e.st));
                chk({e.tag, " scl rises"}, rc, e.rises);
                chk({e.tag, " start shape R3"}, int'(start_seen), 1);
                chk({e.tag, " pending cleared R8"}, int'(start_pending), 0);
                if (e.chk_low) chk({e.tag, " pulse low time R7"}, last_low, HALF);
            end
        end
        irq_prev <= irq;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; hold_m = 0; ext_scl_low = 1'b0; bus_free = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic request(bit rep, int m, logic [7:0] st, int rises, bit lowchk, string tag);
        exp_t e;
        e.st = st; e.rises = rises; e.chk_low = lowchk; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        hold_m = m;
        rc_clr = 1'b1;
        if (rep) req_rep = 1'b1; else req_start = 1'b1;
        @(negedge clk);
        rc_clr = 1'b0; req_rep = 1'b0; req_start = 1'b0;
    endtask

    task automatic wait_irq(string tag);
        int n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " irq reached"}, int'(irq), 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 sda_pd", int'(sda_pd), 0);
        chk("R9 scl_pd", int'(scl_pd), 0);
        chk("R9 status", int'(status), 'hF8);
        chk("R9 irq", int'(irq), 0);
        chk("R9 pending", int'(start_pending), 0);

        // plain START, SDA free: status 08h, no extra clocks
        request(0, 0, 8'h08, 0, 0, "R3 clean start");
        wait_irq("R3 clean start");

        // repeated START from held bus: one release edge, status 10h
        request(1, 0, 8'h10, 1, 0, "R5 repeated clean");
        chk("R8 irq cleared by request", int'(irq), 0);
        wait_irq("R5 repeated clean");

        // stuck SDA for one edge: one group of two pulses
        do_reset();
        request(0, 1, 8'h08, 2, 1, "R1 stuck one edge");
        wait_irq("R1 stuck one edge");

        // stuck SDA for three edges: rounds up to two groups
        do_reset();
        request(0, 3, 8'h08, 4, 1, "R2 stuck three edges");
        wait_irq("R2 stuck three edges");

        // repeated START with SDA stuck for two edges
        request(1, 2, 8'h10, 3, 1, "R5 repeated stuck");
        wait_irq("R5 repeated stuck");

        // busy bus: request waits until the forced timeout
        do_reset();
        bus_free = 1'b0;
        request(0, 0, 8'h08, 0, 0, "R4 forced clean");
        repeat (60) @(negedge clk);
        chk("R4 busy no irq", int'(irq), 0);
        chk("R4 busy no sda drive", int'(sda_pd), 0);
        chk("R4 busy no scl drive", int'(scl_drove), 0);
        chk("R8 busy still pending", int'(start_pending), 1);
        force_tmo = 1'b1;
        @(negedge clk);
        force_tmo = 1'b0;
        wait_irq("R4 forced clean");

        // forced access into a stuck SDA
        do_reset();
        bus_free = 1'b0;
        request(0, 1, 8'h08, 2, 1, "R4 forced stuck");
        force_tmo = 1'b1;
        @(negedge clk);
        force_tmo = 1'b0;
        wait_irq("R4 forced stuck");

        // SCL held low from outside: block waits without clocking
        do_reset();
        ext_scl_low = 1'b1;
        request(0, 1, 8'h08, 1, 0, "R6 scl stuck");
        repeat (100) @(negedge clk);
        chk("R6 no scl drive while low", int'(scl_drove), 0);
        chk("R6 no irq while low", int'(irq), 0);
        chk("R6 still pending", int'(start_pending), 1);
        ext_scl_low = 1'b0;
        wait_irq("R6 scl stuck");

        chk("scoreboard drained", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule